// File: doc/BRIEF.md
# Power Sequencer Register Slave

This block is a byte-oriented slave for a two-wire SMBus/I2C-style bus, built for the control side of a power sequencer. The system clock oversamples SCL and SDA, and the block pulls SDA low through an open-drain enable. It offers two byte registers. A read-only status byte, taken from the sequencer's gate and status lines, sits at register 00h. A writable shutdown byte at register FFh drives one force-off bit per gate back into the sequencer. Every other register number is refused.

The 7-bit slave address is a fixed 4-bit prefix (parameter) followed by three strap inputs, so eight of these blocks can share one bus. A write carries the slave address, a register-pointer byte and then data bytes. A read first needs a write that carries only the pointer, then a repeated start and the slave address with R/W set. The pointer survives stops, so a later plain read returns the same register again.

Top module: `smbus_pwr_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {ID_HI, addr_sel_i}. An acknowledge is sda_oe_o high during the ninth SCL high phase of a byte. A byte with a different address gets no acknowledge, and the rest of that transaction is ignored.
- R2: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A stop or repeated start at any bit returns the engine to idle, releases SDA and keeps the register pointer. A data byte cut off part way changes no register.
- R3: After a write address, a pointer byte of 00h or FFh is acknowledged and becomes the pointer. Any other value is not acknowledged, leaves the pointer unchanged and makes the block ignore the rest of the transaction.
- R4: With the pointer at FFh, each received data byte is acknowledged and loaded into force_off_o when its eighth bit is taken. Successive bytes go to the same register, so the last one wins.
- R5: With the pointer at 00h, data bytes are acknowledged but leave force_off_o unchanged.
- R6: After an acknowledged address byte with R/W=1, the block sends the selected register MSB first, one bit per SCL low phase. Pointer 00h returns status_i as sampled at the start of the byte. Pointer FFh returns the shutdown register.
- R7: A master acknowledge (SDA low on the ninth clock) makes the block send the same register again. A master not-acknowledge makes it release SDA until the next start.
- R8: After reset, force_off_o is zero (no gate forced off), SDA is released and the pointer selects the status register.
- R9: sda_oe_o changes only after a falling SCL edge, or on a start or stop. It never changes during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| addr_sel_i | input | 3 | Strapped low bits of the slave address |
| status_i | input | 8 | Gate and sequencer status returned at register 00h |
| force_off_o | output | 8 | Per-gate force-off bits, register FFh |

## Verification
Two pairs of events are made to fall together. In the first, a stop arrives while a data byte is half shifted in for register FFh. The block must drop the byte, keep force_off_o as it was and keep the pointer at FFh. The bench judges this by comparing force_off_o with its model on every idle clock and by a plain read that follows. In the second, a repeated start lands right after the pointer acknowledge, and the first read bit is loaded on the same falling edge that ends the address acknowledge. Each returned bit is compared with the bench's behavioural copy of the registers, and a monitor checks on every clock that SDA never moves while SCL is high.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sr[SYNC_STAGES-1];
      sda_q  <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_s      = scl_sr[SYNC_STAGES-1];
  assign sda_o      = sda_sr[SYNC_STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_bit_engine.sv
module smb_bit_engine #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ack_i,
  input  logic              tx_en_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              mack_valid_o,
  output logic              mack_o,
  output logic              sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              active, ack_pend, oe;

  assign rx_byte_o    = {rx_sh[BYTE_W-2:0], sda_i};
  assign byte_valid_o = active & scl_rise_i & (cnt == LAST_BIT);
  assign mack_valid_o = active & scl_rise_i & (cnt == ACK_BIT);
  assign mack_o       = ~sda_i;
  assign sda_oe_o     = oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      active   <= 1'b0;
      ack_pend <= 1'b0;
      oe       <= 1'b0;
    end else if (start_i || stop_i) begin
      cnt      <= '0;
      active   <= start_i;
      ack_pend <= 1'b0;
      oe       <= 1'b0;
    end else if (active) begin
      if (scl_rise_i) begin
        if (cnt < ACK_END) cnt <= cnt + 1'b1;
        if (cnt < ACK_BIT) rx_sh <= rx_byte_o;
        if (byte_valid_o) ack_pend <= ack_i;
      end else if (scl_fall_i) begin
        if (cnt == ACK_BIT) begin
          oe       <= ack_pend;
          ack_pend <= 1'b0;
        end else if (cnt == ACK_END) begin
          cnt <= '0;
          if (tx_en_i) begin
            oe    <= ~tx_data_i[BYTE_W-1];
            tx_sh <= {tx_data_i[BYTE_W-2:0], 1'b0};
          end else begin
            oe <= 1'b0;
          end
        end else if (cnt != '0 && tx_en_i) begin
          oe    <= ~tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  // SDA moves only on the cycle after a synchronized SCL fall
  p_oe_rise_after_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));
  p_oe_fall_after_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));
  p_release_on_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !sda_oe_o);
endmodule

// File: rtl/smb_reg_ctrl.sv
module smb_reg_ctrl
  import smb_regs_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter int          SEL_W   = 3,
  parameter int          ID_W    = BYTE_W - 1 - SEL_W,
  parameter logic [ID_W-1:0] ID_HI = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              mack_valid_i,
  input  logic              mack_i,
  output logic              ack_o,
  output logic              tx_en_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic [BYTE_W-1:0] force_off_o
);
  localparam logic [BYTE_W-1:0] PTR_STATUS = '0;
  localparam logic [BYTE_W-1:0] PTR_SHDN   = '1;

  smb_state_e        state;
  logic              ptr_shdn;
  logic [BYTE_W-1:0] shdn_q;
  logic [BYTE_W-2:0] dev_addr;
  logic              addr_hit, ptr_ok;

  assign dev_addr = {ID_HI, addr_sel_i};
  assign addr_hit = (rx_byte_i[BYTE_W-1:1] == dev_addr);
  assign ptr_ok   = (rx_byte_i == PTR_STATUS) || (rx_byte_i == PTR_SHDN);

  always_comb begin
    case (state)
      ST_ADDR:  ack_o = addr_hit;
      ST_PTR:   ack_o = ptr_ok;
      ST_WDATA: ack_o = 1'b1;
      default:  ack_o = 1'b0;
    endcase
  end

  assign tx_en_o     = (state == ST_RDATA);
  assign tx_data_o   = ptr_shdn ? shdn_q : status_i;
  assign force_off_o = shdn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      ptr_shdn <= 1'b0;
      shdn_q   <= '0;
    end else if (start_i) begin
      state <= ST_ADDR;
    end else if (stop_i) begin
      state <= ST_IDLE;
    end else if (byte_valid_i) begin
      case (state)
        ST_ADDR:  state <= !addr_hit ? ST_SKIP : (rx_byte_i[0] ? ST_RDATA : ST_PTR);
        ST_PTR: begin
          if (ptr_ok) begin
            ptr_shdn <= rx_byte_i[0];
            state    <= ST_WDATA;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_WDATA: if (ptr_shdn) shdn_q <= rx_byte_i;
        default:  ;
      endcase
    end else if (mack_valid_i && state == ST_RDATA && !mack_i) begin
      state <= ST_SKIP;
    end
  end

  p_addr_miss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && state == ST_ADDR && !start_i && !stop_i &&
     rx_byte_i[BYTE_W-1:1] != dev_addr) |=> (state == ST_SKIP));
  p_bad_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && state == ST_PTR && !start_i && !stop_i &&
     rx_byte_i != PTR_STATUS && rx_byte_i != PTR_SHDN) |=> (state == ST_SKIP && $stable(ptr_shdn)));
  p_status_wr_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && state == ST_WDATA && !ptr_shdn) |=> $stable(force_off_o));
  p_stop_keeps_ptr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state == ST_IDLE && $stable(ptr_shdn) && $stable(force_off_o)));
  p_nack_ends_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mack_valid_i && state == ST_RDATA && !mack_i && !start_i && !stop_i) |=> (state == ST_SKIP));
endmodule

// File: rtl/smbus_pwr_regs.sv
module smbus_pwr_regs #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ID_HI       = 4'b1011
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] addr_sel_i,
  input  logic [7:0] status_i,
  output logic [7:0] force_off_o
);
  localparam int BYTE_W = 8;

  logic              sda_s, scl_rise, scl_fall, start, stop;
  logic              byte_valid, mack_valid, mack, ack, tx_en;
  logic [BYTE_W-1:0] rx_byte, tx_data;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  smb_bit_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .ack_i(ack), .tx_en_i(tx_en), .tx_data_i(tx_data),
    .byte_valid_o(byte_valid), .rx_byte_o(rx_byte),
    .mack_valid_o(mack_valid), .mack_o(mack), .sda_oe_o
  );

  smb_reg_ctrl #(.BYTE_W(BYTE_W), .SEL_W(3), .ID_W(4), .ID_HI(ID_HI)) u_ctrl (
    .clk_i, .rst_ni, .addr_sel_i, .status_i,
    .start_i(start), .stop_i(stop),
    .byte_valid_i(byte_valid), .rx_byte_i(rx_byte),
    .mack_valid_i(mack_valid), .mack_i(mack),
    .ack_o(ack), .tx_en_o(tx_en), .tx_data_o(tx_data),
    .force_off_o
  );
endmodule

// File: tb/smbus_pwr_regs_tb.sv
module smbus_pwr_regs_tb;
  localparam int CLK_P = 10;
  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'b010;
  logic [7:0] status_val = 8'h00;
  logic sda_oe, sda_bus;
  logic [7:0] force_off;

  int total = 0, bad = 0;
  bit busy = 1'b1;
  bit done = 1'b0;
  logic [7:0] exp_force = 8'h00;
  bit exp_ptr_ff = 1'b0;
  logic last_bus;
  int hi_cnt = 0;
  logic prev_oe = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smbus_pwr_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_sel_i(sel), .status_i(status_val),
    .force_off_o(force_off)
  );

  function automatic logic [6:0] dev();
    return {4'b1011, sel};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      hi_cnt = scl_m ? hi_cnt + 1 : 0;
      if (hi_cnt > 3) chk(sda_oe == prev_oe, "R9 sda moved while scl high", sda_oe, prev_oe);
      if (!busy) chk(force_off == exp_force, "R4/R5 force_off vs model", force_off, exp_force);
      prev_oe = sda_oe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
    last_bus = sda_bus; tick(Q); scl_m = 1'b0;
  endtask

  task automatic m_start();
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic m_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_out(1'b1);
    ack = ~last_bus;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      bit_out(1'b1);
      b[i] = last_bus;
    end
    bit_out(~mack);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d0,
                          input int n, input string tag);
    bit ack, pok;
    busy = 1'b1;
    m_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == (a == dev()), {tag, " R1 address ack"}, ack, a == dev());
    if (ack) begin
      send_byte(p, ack);
      pok = (p == 8'h00) || (p == 8'hFF);
      chk(ack == pok, {tag, " R3 pointer ack"}, ack, pok);
      if (ack) begin
        exp_ptr_ff = (p == 8'hFF);
        for (int i = 0; i < n; i++) begin
          send_byte(d0 + 8'(i), ack);
          chk(ack == 1'b1, {tag, " data ack"}, ack, 1);
          if (exp_ptr_ff) exp_force = d0 + 8'(i);
        end
      end
    end
    m_stop();
    busy = 1'b0;
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input bit set_ptr,
                         input logic [7:0] p, input string tag);
    bit ack;
    logic [7:0] b, e;
    busy = 1'b1;
    m_start();
    if (set_ptr) begin
      send_byte({a, 1'b0}, ack);
      chk(ack, {tag, " R1 dummy write ack"}, ack, 1);
      send_byte(p, ack);
      chk(ack, {tag, " R3 pointer ack"}, ack, 1);
      exp_ptr_ff = (p == 8'hFF);
      m_start();
    end
    send_byte({a, 1'b1}, ack);
    chk(ack == (a == dev()), {tag, " R1 read address ack"}, ack, a == dev());
    if (ack) begin
      for (int i = 0; i < n; i++) begin
        read_byte(i < n - 1, b);
        e = exp_ptr_ff ? exp_force : status_val;
        chk(b == e, {tag, " R6 read data"}, b, e);
      end
      // after master nack the bus must stay released (R7)
      for (int i = 0; i < 8; i++) begin
        bit_out(1'b1);
        chk(last_bus == 1'b1, {tag, " R7 released after nack"}, last_bus, 1);
      end
    end
    m_stop();
    busy = 1'b0;
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk(force_off == 8'h00, "R8 reset force_off", force_off, 0);
    chk(sda_oe == 1'b0, "R8 reset sda released", sda_oe, 0);
    busy = 1'b0;

    status_val = 8'h5C;
    do_read(dev(), 1, 1'b0, 8'h00, "R8 default pointer is status");

    do_write(dev(), 8'hFF, 8'hA5, 1, "R4 shutdown write");
    do_write(dev(), 8'h00, 8'h33, 2, "R5 status write ignored");
    do_write(dev() ^ 7'h01, 8'hFF, 8'h0F, 1, "R1 wrong strap address");
    do_write(dev(), 8'h42, 8'h77, 1, "R3 bad pointer");
    do_read(dev(), 1, 1'b0, 8'h00, "R3 pointer kept after refusal");

    do_read(dev(), 3, 1'b1, 8'hFF, "R7 random read of shutdown");
    do_write(dev(), 8'hFF, 8'h3C, 3, "R4 multi-byte last wins");
    do_read(dev(), 1, 1'b1, 8'hFF, "R4 readback");

    status_val = 8'h96;
    do_read(dev(), 2, 1'b1, 8'h00, "R6 status read");
    status_val = 8'hC3;
    do_read(dev(), 1, 1'b0, 8'h00, "R6 status follows input");

    // stop in the middle of a data byte (R2)
    busy = 1'b1;
    m_start();
    send_byte({dev(), 1'b0}, ack);
    send_byte(8'hFF, ack);
    exp_ptr_ff = 1'b1;
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    m_stop();
    busy = 1'b0;
    tick(8);
    chk(force_off == exp_force, "R2 aborted byte dropped", force_off, exp_force);
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
    do_read(dev(), 1, 1'b0, 8'h00, "R2 pointer kept after stop");

    sel = 3'b101;
    tick(4);
    do_write(dev(), 8'hFF, 8'h81, 1, "R1 new strap address");
    do_read(dev(), 1, 1'b1, 8'hFF, "R1 new strap read");
    do_read(7'h4A, 1, 1'b0, 8'h00, "R1 foreign read address");

    tick(20);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule